// File: doc/BRIEF.md
# Three-Channel Prescaled Interval Timer

This peripheral holds three independent 16-bit up-counters. Software reaches them through a word-addressed register port with a write strobe, a read strobe and registered read data. Each channel has a selectable power-of-two prescaler that runs from the system clock. A channel can run freely, wrapping at the top of its range, or in interval mode. In interval mode it returns to zero after it reaches a programmed limit and flags an interrupt. Each channel drives its own interrupt line, gated by an enable bit.

A typical use splits the channels. One channel runs freely as a timebase that software samples. Another is set up as an interval timer for periodic or one-shot events: software disables it, loads the limit, then restarts it from zero with a single write. The interrupt status clears when it is read, so reading it acknowledges the interrupt in one access.

Top module: `trio_interval_timer`

## Requirements
- R1: Registers are grouped by kind, and channel k (k = 0..2) sits at the group base plus 4*k. The byte group bases are: clock control 0x00, counter control 0x0C, counter value 0x18 (read-only), interval 0x24, interrupt status 0x54 (read-only) and interrupt enable 0x60. Read data appears on `rd_data` in the cycle after `rd_en` and holds until the next read. Reads of unmapped addresses return 0.
- R2: Clock control bit 0 turns the prescaler on, and bits [4:1] hold an exponent N. With the prescaler on, the counter advances once every 2^(N+1) clocks. With it off, the counter advances on every clock.
- R3: Clock control bit 5 (clock source select) is stored and read back, and it has no effect on counting.
- R4: Counter control bit 0 set holds the counter at its value. After reset, counter control reads 0x01 and every other register reads 0.
- R5: Writing counter control with bit 4 set clears the counter and the prescaler divider. Bit 4 always reads back as 0.
- R6: Any write to clock control restarts the prescaler divider, so the next advance comes a full 2^(N+1) clocks after the write.
- R7: Outside interval mode, the counter wraps from 0xFFFF to 0 and no interrupt status is raised.
- R8: Counter control bit 1 selects interval mode. In this mode, a counter equal to the interval value returns to 0 on its next advance, and that advance sets interrupt status bit 0.
- R9: A read of interrupt status returns the pending bit and clears it. An event that lands on the same clock as the read stays pending.
- R10: Interrupt output k is high exactly when status bit 0 and enable bit 0 of channel k are both set.
- R11: Counter control bits 0, 1, 2, 3 and 5 read back as written, so writing 0x23 leaves a stopped interval timer that reads 0x23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W (8) | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W (32) | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W (32) | Registered read data |
| irq | output | NUM_CH (3) | Per-channel interrupt lines |

## Verification
The bench uses the default parameters: three channels, 16-bit counters and a 4-bit prescale exponent. Random cases keep the exponent between 0 and 3 and the interval between 1 and 20. With those settings, prescaled advances, interval wraps and interrupt raising all happen within a few hundred clocks, so many combinations fit in a short run. One directed case runs a channel unprescaled for more than 65536 clocks to reach the 16-bit wrap. Other directed cases place a status read on the exact clock of an interval event and rewrite the clock control in the middle of a prescale period.

// File: rtl/ttmr_pkg.sv
package ttmr_pkg;
  // word index (byte address / 4) of each register group's channel 0 entry
  localparam int WORD_CLK = 0;
  localparam int WORD_CNT = 3;
  localparam int WORD_VAL = 6;
  localparam int WORD_INT = 9;
  localparam int WORD_ISR = 21;
  localparam int WORD_IER = 24;

  // counter-control bit positions
  localparam int CC_STOP  = 0;
  localparam int CC_INTV  = 1;
  localparam int CC_CLEAR = 4;
  localparam int CC_W     = 6;
endpackage

// File: rtl/ttmr_prescaler.sv
module ttmr_prescaler #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             psc_en,
  input  logic [EXP_W-1:0] psc_exp,
  input  logic             restart,
  output logic             tick
);
  localparam int DIV_W = 1 << EXP_W;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;

  // 2^(exp+1)-1 as an all-ones mask
  assign limit = {DIV_W{1'b1}} >> (DIV_W - 1 - int'(psc_exp));
  assign tick  = run && (!psc_en || (div_q == limit));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      div_q <= '0;
    end else if (run && psc_en) begin
      div_q <= (div_q == limit) ? '0 : div_q + 1'b1;
    end
  end

  // R2
  single_tick_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(tick) && $past(psc_en) && psc_en && !$past(restart)) |-> !tick);
endmodule

// File: rtl/ttmr_channel.sv
module ttmr_channel
  import ttmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_we,
  input  logic             cnt_we,
  input  logic             int_we,
  input  logic             ier_we,
  input  logic             isr_rd,
  input  logic [CNT_W-1:0] wdata,
  output logic [EXP_W+1:0] clk_ctl_o,
  output logic [CC_W-1:0]  cnt_ctl_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] interval_o,
  output logic             status_o,
  output logic             ier_o,
  output logic             irq_o
);
  localparam int CK_W = EXP_W + 2;

  logic [CK_W-1:0]  clk_ctl_q;
  logic [CC_W-1:0]  cnt_ctl_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] interval_q;
  logic             status_q;
  logic             ier_q;
  logic             clear_req;
  logic             tick;
  logic             at_limit;
  logic             evt;

  assign clear_req = cnt_we && wdata[CC_CLEAR];
  assign at_limit  = cnt_ctl_q[CC_INTV] && (count_q == interval_q);
  assign evt       = tick && at_limit && !clear_req;

  ttmr_prescaler #(.EXP_W(EXP_W)) u_psc (
    .clk     (clk),
    .rst     (rst),
    .run     (!cnt_ctl_q[CC_STOP]),
    .psc_en  (clk_ctl_q[0]),
    .psc_exp (clk_ctl_q[EXP_W:1]),
    .restart (clk_we || clear_req),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_ctl_q  <= '0;
      cnt_ctl_q  <= CC_W'(1);
      interval_q <= '0;
      ier_q      <= 1'b0;
    end else begin
      if (clk_we) clk_ctl_q <= wdata[CK_W-1:0];
      if (cnt_we) cnt_ctl_q <= {wdata[5], 1'b0, wdata[3:0]};
      if (int_we) interval_q <= wdata;
      if (ier_we) ier_q <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear_req) begin
      count_q <= '0;
    end else if (tick) begin
      count_q <= at_limit ? '0 : count_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= 1'b0;
    end else if (isr_rd) begin
      status_q <= evt;
    end else if (evt) begin
      status_q <= 1'b1;
    end
  end

  assign clk_ctl_o  = clk_ctl_q;
  assign cnt_ctl_o  = cnt_ctl_q;
  assign count_o    = count_q;
  assign interval_o = interval_q;
  assign status_o   = status_q;
  assign ier_o      = ier_q;
  assign irq_o      = status_q && ier_q;

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(clear_req) |-> (count_q == '0) && !cnt_ctl_q[CC_CLEAR]);

  // R4
  stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt_ctl_q[CC_STOP]) && !$past(cnt_we)) |-> $stable(count_q));

  // R8
  intv_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $past(evt) |-> status_o);

  // R9
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(isr_rd) && !$past(evt)) |-> !status_o);

  // R7
  free_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(tick) && !$past(cnt_ctl_q[CC_INTV]) && !$past(clear_req) &&
     ($past(count_q) == {CNT_W{1'b1}}) && !$past(isr_rd))
    |-> (count_q == '0) && (status_o == $past(status_o)));
endmodule

// File: rtl/trio_interval_timer.sv
module trio_interval_timer
  import ttmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16,
  parameter int EXP_W  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_CH-1:0] irq
);
  localparam int WA_W = ADDR_W - 2;
  localparam int CK_W = EXP_W + 2;

  logic [WA_W-1:0]   word;
  logic [CK_W-1:0]   clk_ctl [NUM_CH];
  logic [CC_W-1:0]   cnt_ctl [NUM_CH];
  logic [CNT_W-1:0]  count   [NUM_CH];
  logic [CNT_W-1:0]  intv    [NUM_CH];
  logic [NUM_CH-1:0] status;
  logic [NUM_CH-1:0] ier;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rd_q;
  logic              unused_bits;

  assign word        = addr[ADDR_W-1:2];
  assign unused_bits = ^{wr_data[DATA_W-1:CNT_W], addr[1:0]};

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    ttmr_channel #(.CNT_W(CNT_W), .EXP_W(EXP_W)) u_ch (
      .clk        (clk),
      .rst        (rst),
      .clk_we     (wr_en && (word == WA_W'(WORD_CLK + k))),
      .cnt_we     (wr_en && (word == WA_W'(WORD_CNT + k))),
      .int_we     (wr_en && (word == WA_W'(WORD_INT + k))),
      .ier_we     (wr_en && (word == WA_W'(WORD_IER + k))),
      .isr_rd     (rd_en && (word == WA_W'(WORD_ISR + k))),
      .wdata      (wr_data[CNT_W-1:0]),
      .clk_ctl_o  (clk_ctl[k]),
      .cnt_ctl_o  (cnt_ctl[k]),
      .count_o    (count[k]),
      .interval_o (intv[k]),
      .status_o   (status[k]),
      .ier_o      (ier[k]),
      .irq_o      (irq[k])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (word == WA_W'(WORD_CLK + k)) rd_mux = DATA_W'(clk_ctl[k]);
      if (word == WA_W'(WORD_CNT + k)) rd_mux = DATA_W'(cnt_ctl[k]);
      if (word == WA_W'(WORD_VAL + k)) rd_mux = DATA_W'(count[k]);
      if (word == WA_W'(WORD_INT + k)) rd_mux = DATA_W'(intv[k]);
      if (word == WA_W'(WORD_ISR + k)) rd_mux = DATA_W'(status[k]);
      if (word == WA_W'(WORD_IER + k)) rd_mux = DATA_W'(ier[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_mux;
    end
  end

  assign rd_data = rd_q;

  // R1
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rd_data));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (irq & ~status) == '0);
endmodule

// File: tb/trio_interval_timer_test.sv
`timescale 1ns/1ps
module trio_interval_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [2:0]  irq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trio_interval_timer uut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  function automatic logic [7:0] a_clk(int k); return 8'(8'h00 + 4*k); endfunction
  function automatic logic [7:0] a_cnt(int k); return 8'(8'h0C + 4*k); endfunction
  function automatic logic [7:0] a_val(int k); return 8'(8'h18 + 4*k); endfunction
  function automatic logic [7:0] a_int(int k); return 8'(8'h24 + 4*k); endfunction
  function automatic logic [7:0] a_isr(int k); return 8'(8'h54 + 4*k); endfunction
  function automatic logic [7:0] a_ier(int k); return 8'(8'h60 + 4*k); endfunction

  // ticks seen after n clocks with divide d
  function automatic int exp_count(int n, int d, bit intv_mode, int lim);
    int t = n / d;
    return intv_mode ? t % (lim + 1) : t % 65536;
  endfunction

  function automatic bit exp_pend(int n, int d, bit intv_mode, int lim);
    return intv_mode && ((n / d) >= lim + 1);
  endfunction

  task automatic check(string req, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output int v);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = int'(rd_data);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    rd(a_cnt(0), v); check("R4 reset ctl", v, 1);
    rd(a_clk(1), v); check("R4 reset clk", v, 0);
    rd(a_val(2), v); check("R4 reset count", v, 0);
    check("R10 reset irq", int'(irq), 0);

    // self-clearing restart bit and stored bits
    wr(a_cnt(0), 32'h12);
    rd(a_cnt(0), v); check("R5 restart bit reads 0", v, 2);
    wr(a_cnt(0), 32'h23);
    rd(a_cnt(0), v); check("R11 0x23 readback", v, 32'h23);
    begin
      int c1;
      rd(a_val(0), c1);
      repeat (40) @(negedge clk);
      rd(a_val(0), v); check("R4 stopped holds", v, c1);
    end

    // source select stored, unprescaled full rate
    wr(a_clk(1), 32'h20);
    rd(a_clk(1), v); check("R3 source bit readback", v, 32'h20);
    wr(a_cnt(1), 32'h10);
    repeat (37) @(negedge clk);
    rd(a_val(1), v); check("R3 R2 full rate count", v, 37);

    // clock-control rewrite restarts divider (N=3, divide 16)
    wr(a_clk(1), 32'h07);
    wr(a_cnt(1), 32'h10);
    repeat (8) @(negedge clk);
    wr(a_clk(1), 32'h07);
    repeat (15) @(negedge clk);
    rd(a_val(1), v); check("R6 no tick before full period", v, 0);
    rd(a_val(1), v); check("R6 tick after full period", v, 1);

    // event coinciding with a status read stays pending
    wr(a_ier(2), 32'h1);
    wr(a_clk(2), 32'h0);
    wr(a_int(2), 32'd5);
    wr(a_cnt(2), 32'h12);
    repeat (5) @(negedge clk);
    rd(a_isr(2), v); check("R9 read on event cycle", v, 0);
    check("R10 irq pending after coincident event", int'(irq[2]), 1);
    rd(a_isr(2), v); check("R9 event kept pending", v, 1);
    wr(a_cnt(2), 32'h03);
    rd(a_isr(2), v); check("R9 cleared by read", v, 0);
    check("R10 irq low after clear", int'(irq[2]), 0);

    // free-running wrap with no interrupt
    wr(a_cnt(2), 32'h10);
    repeat (65536 + 5) @(negedge clk);
    rd(a_val(2), v); check("R7 wrap count", v, 5);
    rd(a_isr(2), v); check("R7 no status on wrap", v, 0);
    check("R7 no irq on wrap", int'(irq[2]), 0);

    // unmapped addresses
    rd(8'h30, v); check("R1 unmapped 0x30", v, 0);
    rd(8'h70, v); check("R1 unmapped 0x70", v, 0);

    // random configurations
    for (int it = 0; it < 24; it++) begin
      int ch, n, lim, d, nexp, ie_b;
      bit pen, mode;
      ch   = int'($urandom_range(0, 2));
      pen  = 1'($urandom_range(0, 1));
      nexp = int'($urandom_range(0, 3));
      mode = 1'($urandom_range(0, 1));
      lim  = int'($urandom_range(1, 20));
      n    = int'($urandom_range(0, 300));
      ie_b = int'($urandom_range(0, 1));
      d    = pen ? (1 << (nexp + 1)) : 1;
      wr(a_cnt(ch), 32'h1);
      wr(a_clk(ch), 32'((nexp << 1) | int'(pen)));
      wr(a_int(ch), 32'(lim));
      wr(a_ier(ch), 32'(ie_b));
      rd(a_isr(ch), v);
      wr(a_cnt(ch), 32'(32'h10 | (int'(mode) << 1)));
      repeat (n) @(negedge clk);
      check("R10 irq gate", int'(irq[ch]),
            int'(exp_pend(n, d, mode, lim)) & ie_b);
      rd(a_val(ch), v);
      check("R2 R8 R1 count", v, exp_count(n, d, mode, lim));
      rd(a_isr(ch), v);
      check("R8 status", v, int'(exp_pend(n + 1, d, mode, lim)));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule